// File: doc/BRIEF.md
# Address Generator with Register Writeback

This block forms the memory address for load and store operations from a base value, an index scaled by 1, 2, 4 or 8, and a sign-extended 16-bit displacement. Besides the access address it can return a second value, the update for an address register, carried on a writeback port separate from the normal result port. In pre-modify form the computed address is used for the access and saved back. In post-modify form the access uses the unmodified base, and the register then receives the computed address.

When software knows that the base plus scaled index is aligned, it can ask for the displacement to be merged with a bitwise OR instead of an add. If any displacement bit collides with a set bit of that sum, the block falls back to the add and raises a misalignment flag. A build-time option restricts address writeback to stores, because a load already occupies the result port. A load that asks for writeback under that option raises an illegal-combination flag, and no update is issued.

Every output is registered, so results appear one cycle after the request. A two-state output machine tracks whether a result is on display. The states are OS_IDLE (nothing presented) and OS_SHOW (outputs valid). The transitions are: OS_IDLE to OS_SHOW on a request, OS_SHOW to OS_SHOW on a further request, and OS_SHOW to OS_IDLE when no request arrives.

Top module: `agu_wb_top`

## Requirements
- R1: While reset is held every output is 0. `acc_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 otherwise.
- R2: With `mode` = 0 (plain) and `or_idx` = 0, `acc_addr` = base + index*S + sext(offset), where S is 1, 2, 4 or 8 for `scale_sel` codes 0, 1, 2 and 3.
- R3: With `mode` = 1 (pre-modify) and writeback allowed, `acc_addr` and `upd_value` both equal the computed address, `upd_valid` = 1, and `upd_tag` = `dst_tag`.
- R4: With `mode` = 2 (post-modify), `acc_addr` equals `base`. When writeback is allowed, `upd_value` equals the computed address and `upd_valid` = 1.
- R5: With `mode` = 0 (plain) or 3 (reserved, acts as plain), `upd_valid` stays 0 and `illegal` stays 0.
- R6: With `or_idx` = 1 and no common set bit between the sum and the sign-extended offset, the computed address is their bitwise OR and `misalign` = 0.
- R7: With `or_idx` = 1 and at least one common set bit, `misalign` = 1 and the computed address uses the add. With `or_idx` = 0, `misalign` = 0.
- R8: With the default STORE_ONLY_WB = 1, a load (`op_store` = 0) in mode 1 or 2 gives `illegal` = 1 and `upd_valid` = 0. The access is still issued, with the address for its mode.
- R9: A store (`op_store` = 1) in mode 1 or 2 gives `illegal` = 0 and an update.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale_sel | input | 2 | Index scale code: 0→1, 1→2, 2→4, 3→8 |
| offset | input | 16 | Signed displacement |
| op_store | input | 1 | 1 = store, 0 = load |
| mode | input | 2 | 0 plain, 1 pre-modify, 2 post-modify, 3 reserved (plain) |
| or_idx | input | 1 | Merge displacement by OR when possible |
| dst_tag | input | 5 | Address register to update |
| acc_valid | output | 1 | Access address valid |
| acc_addr | output | 32 | Memory access address |
| upd_valid | output | 1 | Register update valid |
| upd_tag | output | 5 | Register tag for the update |
| upd_value | output | 32 | Value written back to the address register |
| illegal | output | 1 | Load requested writeback while stores-only applies |
| misalign | output | 1 | OR merge refused because of overlapping bits |

## Verification
The assertions check, on every cycle, the one-cycle handshake from request to valid and the dependencies between flags. An update never appears without an access, never appears together with `illegal`, and a misalign flag never appears without a valid access. They also check that the post-modify access address repeats the previous cycle's base, and that the pre-modify update equals the access address. The arithmetic itself can only be shown by the bench's sweep. That sweep covers every mode, operation type, scale code and merge choice over operand sets that include colliding and disjoint OR operands, negative displacements and wraparound past 2^32.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN = 2'd0,
        AM_PRE   = 2'd1,
        AM_POST  = 2'd2,
        AM_RSVD  = 2'd3
    } amode_e;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_SHOW = 1'b1
    } ostate_e;

endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [1:0]    sel,
    output logic [AW-1:0] scaled
);
    always_comb begin
        unique case (sel)
            2'd0:    scaled = idx;
            2'd1:    scaled = {idx[AW-2:0], 1'b0};
            2'd2:    scaled = {idx[AW-3:0], 2'b00};
            default: scaled = {idx[AW-4:0], 3'b000};
        endcase
    end
endmodule

// File: rtl/agu_combine.sv
module agu_combine #(
    parameter int AW    = 32,
    parameter int OFW   = 16,
    parameter bit OR_EN = 1'b1
) (
    input  logic [AW-1:0]  sum,
    input  logic [OFW-1:0] off,
    input  logic           or_req,
    output logic [AW-1:0]  ea,
    output logic           mis
);
    localparam int EXT = AW - OFW;

    logic [AW-1:0] off_x;
    logic [AW-1:0] add_res;

    assign off_x   = {{EXT{off[OFW-1]}}, off};
    assign add_res = sum + off_x;

    generate
        if (OR_EN) begin : g_or
            logic overlap;
            assign overlap = |(sum & off_x);
            assign ea  = (or_req && !overlap) ? (sum | off_x) : add_res;
            assign mis = or_req && overlap;
        end else begin : g_add
            logic unused_or;
            assign unused_or = or_req;
            assign ea  = add_res;
            assign mis = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/agu_wb_policy.sv
module agu_wb_policy
    import agu_pkg::*;
#(
    parameter bit STORE_ONLY = 1'b1
) (
    input  logic [1:0] mode,
    input  logic       is_store,
    output logic       wb_go,
    output logic       bad_combo
);
    logic want;
    assign want = (mode == AM_PRE) || (mode == AM_POST);

    generate
        if (STORE_ONLY) begin : g_store_only
            assign wb_go     = want && is_store;
            assign bad_combo = want && !is_store;
        end else begin : g_any
            logic unused_st;
            assign unused_st = is_store;
            assign wb_go     = want;
            assign bad_combo = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/agu_wb_top.sv
module agu_wb_top
    import agu_pkg::*;
#(
    parameter int AW            = 32,
    parameter int OFW           = 16,
    parameter int TAGW          = 5,
    parameter bit OR_IDX_EN     = 1'b1,
    parameter bit STORE_ONLY_WB = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [1:0]      scale_sel,
    input  logic [OFW-1:0]  offset,
    input  logic            op_store,
    input  logic [1:0]      mode,
    input  logic            or_idx,
    input  logic [TAGW-1:0] dst_tag,
    output logic            acc_valid,
    output logic [AW-1:0]   acc_addr,
    output logic            upd_valid,
    output logic [TAGW-1:0] upd_tag,
    output logic [AW-1:0]   upd_value,
    output logic            illegal,
    output logic            misalign
);
    logic [AW-1:0] scaled;
    logic [AW-1:0] sum;
    logic [AW-1:0] ea;
    logic          mis;
    logic          wb_go;
    logic          bad_combo;
    logic [AW-1:0] acc_nxt;

    agu_scale #(.AW(AW)) u_scale (
        .idx    (index),
        .sel    (scale_sel),
        .scaled (scaled)
    );

    assign sum = base + scaled;

    agu_combine #(.AW(AW), .OFW(OFW), .OR_EN(OR_IDX_EN)) u_comb (
        .sum    (sum),
        .off    (offset),
        .or_req (or_idx),
        .ea     (ea),
        .mis    (mis)
    );

    agu_wb_policy #(.STORE_ONLY(STORE_ONLY_WB)) u_pol (
        .mode      (mode),
        .is_store  (op_store),
        .wb_go     (wb_go),
        .bad_combo (bad_combo)
    );

    assign acc_nxt = (mode == AM_POST) ? base : ea;

    // output state machine
    ostate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: if (req_valid)  state_d = OS_SHOW;
            OS_SHOW: if (!req_valid) state_d = OS_IDLE;
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    logic [AW-1:0]   acc_q;
    logic [AW-1:0]   upd_q;
    logic [TAGW-1:0] tag_q;
    logic            updv_q;
    logic            ill_q;
    logic            mis_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            upd_q  <= '0;
            tag_q  <= '0;
            updv_q <= 1'b0;
            ill_q  <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            updv_q <= req_valid && wb_go;
            ill_q  <= req_valid && bad_combo;
            mis_q  <= req_valid && mis;
            if (req_valid) begin
                acc_q <= acc_nxt;
                upd_q <= ea;
                tag_q <= dst_tag;
            end
        end
    end

    assign acc_valid = (state_q == OS_SHOW);
    assign acc_addr  = acc_q;
    assign upd_valid = updv_q;
    assign upd_value = upd_q;
    assign upd_tag   = tag_q;
    assign illegal   = ill_q;
    assign misalign  = mis_q;
endmodule

// File: rtl/agu_wb_chk.sv
module agu_wb_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    mode,
    input logic          op_store,
    input logic [AW-1:0] base,
    input logic          acc_valid,
    input logic [AW-1:0] acc_addr,
    input logic          upd_valid,
    input logic [AW-1:0] upd_value,
    input logic          illegal,
    input logic          misalign
);
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (acc_valid == $past(req_valid)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !live_q |-> (!acc_valid && !upd_valid && !illegal && !misalign));

    // R9
    upd_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> acc_valid);

    // R8
    illegal_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!upd_valid && acc_valid && !$past(op_store)));

    // R7
    misalign_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> acc_valid);

    // R4
    post_old_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(req_valid) && $past(mode) == 2'd2) |-> (acc_addr == $past(base)));

    // R3
    pre_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && upd_valid && $past(mode) == 2'd1) |-> (upd_value == acc_addr));

    // R5
    plain_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (($past(mode) == 2'd0) || ($past(mode) == 2'd3))) |-> (!upd_valid && !illegal));
endmodule

bind agu_wb_top agu_wb_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_agu_wb_top.sv
module sim_agu_wb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] base, index;
    logic [1:0]  scale_sel, mode;
    logic [15:0] offset;
    logic        op_store, or_idx;
    logic [4:0]  dst_tag;
    logic        acc_valid, upd_valid, illegal, misalign;
    logic [31:0] acc_addr, upd_value;
    logic [4:0]  upd_tag;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    agu_wb_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic ref_model(input logic [31:0] b, input logic [31:0] ix, input logic [1:0] sc,
                             input logic [15:0] of, input logic [1:0] md, input logic st,
                             input logic oi,
                             output logic [31:0] e_acc, output logic [31:0] e_upd,
                             output logic e_updv, output logic e_ill, output logic e_mis);
        logic [31:0] s, ox, ea;
        s  = b + ix * (32'd1 << sc);
        ox = {{16{of[15]}}, of};
        if (oi && ((s & ox) == 32'd0)) begin
            ea = s | ox;
            e_mis = 1'b0;
        end else begin
            ea = s + ox;
            e_mis = oi;
        end
        e_acc  = (md == 2'd2) ? b : ea;
        e_upd  = ea;
        e_updv = (md == 2'd1 || md == 2'd2) && st;
        e_ill  = (md == 2'd1 || md == 2'd2) && !st;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] bs [6];
        logic [31:0] ixs[6];
        logic [15:0] ofs[6];
        logic [31:0] e_acc, e_upd;
        logic        e_updv, e_ill, e_mis;
        string       at;

        bs[0] = 32'h0000_1000; ixs[0] = 32'd3;      ofs[0] = 16'h0010;
        bs[1] = 32'h2000_0000; ixs[1] = 32'd5;      ofs[1] = 16'hFFFC;
        bs[2] = 32'hFFFF_FFF0; ixs[2] = 32'h10;     ofs[2] = 16'h0040; // R10 wrap
        bs[3] = 32'h0000_0100; ixs[3] = 32'h40;     ofs[3] = 16'h0003;
        bs[4] = 32'h0000_0000; ixs[4] = 32'd0;      ofs[4] = 16'h7FFF;
        bs[5] = 32'h1234_5678; ixs[5] = 32'h1111;   ofs[5] = 16'h8000;

        rst_n = 1'b0; req_valid = 1'b0; base = '0; index = '0; scale_sel = '0;
        offset = '0; op_store = 1'b0; mode = '0; or_idx = 1'b0; dst_tag = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset acc_valid", {31'd0, acc_valid}, 32'd0);
        chk("R1 reset upd_valid", {31'd0, upd_valid}, 32'd0);
        chk("R1 reset acc_addr", acc_addr, 32'd0);
        chk("R1 reset flags", {30'd0, illegal, misalign}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle acc_valid", {31'd0, acc_valid}, 32'd0);

        for (int s = 0; s < 6; s++)
            for (int m = 0; m < 4; m++)
                for (int o = 0; o < 2; o++)
                    for (int c = 0; c < 4; c++)
                        for (int q = 0; q < 2; q++) begin
                            req_valid = 1'b1;
                            base = bs[s]; index = ixs[s]; offset = ofs[s];
                            mode = m[1:0]; op_store = o[0]; scale_sel = c[1:0];
                            or_idx = q[0]; dst_tag = 5'(s * 4 + c + m);
                            ref_model(bs[s], ixs[s], c[1:0], ofs[s], m[1:0], o[0], q[0],
                                      e_acc, e_upd, e_updv, e_ill, e_mis);
                            @(negedge clk);
                            if (s == 2)      at = "R10 addr";
                            else if (m == 2) at = "R4 addr";
                            else if (m == 1) at = "R3 addr";
                            else if (q == 1) at = "R6 addr";
                            else             at = "R2 addr";
                            chk("R1 acc_valid", {31'd0, acc_valid}, 32'd1);
                            chk(at, acc_addr, e_acc);
                            chk("R7 misalign", {31'd0, misalign}, {31'd0, e_mis});
                            chk("R8 illegal", {31'd0, illegal}, {31'd0, e_ill});
                            chk((m == 0 || m == 3) ? "R5 upd_valid" : "R9 upd_valid",
                                {31'd0, upd_valid}, {31'd0, e_updv});
                            if (e_updv) begin
                                chk((m == 1) ? "R3 upd_value" : "R4 upd_value", upd_value, e_upd);
                                chk("R3 upd_tag", {27'd0, upd_tag}, {27'd0, 5'(s * 4 + c + m)});
                            end
                        end

        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 drop acc_valid", {31'd0, acc_valid}, 32'd0);
        chk("R1 drop upd_valid", {31'd0, upd_valid}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule